// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (64 x 16)

This block models a small serial EEPROM with 64 words of 16 bits. A host drives it over a three-wire synchronous bus: a chip select (`cs`), a serial clock (`sk`), serial data in (`di`), and a single serial data output (`do_o`) that has its own enable (`do_oe`). All three inputs pass through a two-stage synchronizer into one system clock domain, and the block detects their edges there. Each transaction opens with a rising `cs`. The first 1 seen on `di` is the start bit. Two opcode bits and six address bits follow it, most significant bit first. Write-type commands then take 16 data bits.

A programming command runs only when `cs` falls right after its last required bit, and only if a write-enable latch is set. The word store then updates, and a countdown of `PROG_CYCLES` system clocks marks the block as busy. While the block is busy, a host that raises `cs` sees 0 on `do_o`. Once programming is over, it sees 1. No serial clock is needed to read this status. Reads return a leading 0 and then the word, with the most significant bit first.

Top module: `mw_eeprom`

## Requirements
- R1: A command is framed as a start bit (the first 1 on `di` after `cs` rises; earlier 0s are skipped), then opcode[1:0], then address[5:0], each sampled on a rising `sk` edge with the most significant bit first.
- R2: Opcode 10 (read) makes `do_o` show a 0 after the rising `sk` edge that carries A0. Each later rising edge then presents the next bit of the stored word, bit 15 first. Reads work whether the write-enable latch is set or clear.
- R3: `do_oe` is 0 while `cs` is low and during the command and data input phases. Whenever `do_oe` is 0, `do_o` is 0.
- R4: The write-enable latch is clear after reset. Opcode 00 with address bits [5:4]=11 sets it, and opcode 00 with [5:4]=00 clears it. Both take effect at the falling edge of `cs`.
- R5: Opcode 01 (write) takes 16 data bits after the address, bit 15 first, and stores them at the address.
- R6: Write, erase, write-all and erase-all change no word and start no busy period while the latch is clear.
- R7: A programming command runs only if `cs` falls before any further rising `sk` edge after its last required bit. An extra rising edge cancels the command.
- R8: Opcode 11 (erase) sets the addressed word to FFFF. Opcode 00 with [5:4]=10 sets every word to FFFF.
- R9: Opcode 00 with [5:4]=01 takes 16 data bits and stores that pattern in every word.
- R10: For `PROG_CYCLES` clocks after a programming command starts, `cs` high gives `do_oe`=1 and `do_o`=0. After that period, `cs` high with no start bit gives `do_o`=1. A `cs` assertion that begins while the block is busy is ignored in full.
- R11: After reset every word reads FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data or ready/busy status out |
| do_oe | output | 1 | Output enable for `do_o` |

## Verification
The assertions assume the host keeps each level of `cs`, `sk` and `di` stable for several system clocks. They also assume `cs` and `sk` never change in the same synchronized cycle, so that a `cs` edge and a `sk` edge are never seen together. The bench holds every level for six clocks and changes `di` only while `sk` is low. It lowers `cs` only after `sk` has gone back low. The busy-period checks also assume that no programming command can start while a countdown is running. The stimulus respects this, because a `cs` assertion begun during the countdown is ignored.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CMD_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam int BC_W  = $clog2(DATA_W > CMD_W ? DATA_W : CMD_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_CMD, S_DATA, S_ARMED, S_READ, S_HOLD, S_ABORT} state_t;

  state_t             state;
  logic [1:0]         cs_m, sk_m, di_m;
  logic               cs_d, sk_d;
  logic [CMD_W-1:0]   cmd_q;
  logic [DATA_W-1:0]  data_q, out_sr;
  logic [DATA_W-1:0]  mem [WORDS];
  logic [BC_W-1:0]    bit_cnt;
  logic [CNT_W-1:0]   prog_cnt;
  logic               do_q, wen;

  wire cs_s    = cs_m[1];
  wire sk_s    = sk_m[1];
  wire di_s    = di_m[1];
  wire cs_rise = cs_s & ~cs_d;
  wire cs_fall = ~cs_s & cs_d;
  wire sk_rise = sk_s & ~sk_d;
  wire busy    = prog_cnt != '0;

  wire [CMD_W-1:0] cmd_next = {cmd_q[CMD_W-2:0], di_s};
  wire [1:0] nop  = cmd_next[CMD_W-1 -: 2];
  wire [1:0] next = cmd_next[ADDR_W-1 -: 2];
  wire need_data  = (nop == 2'b01) || (nop == 2'b00 && next == 2'b01);

  wire [1:0] op   = cmd_q[CMD_W-1 -: 2];
  wire [1:0] ext  = cmd_q[ADDR_W-1 -: 2];
  wire is_prog    = (op == 2'b01) || (op == 2'b11) ||
                    (op == 2'b00 && (ext == 2'b01 || ext == 2'b10));
  wire prog_go    = cs_fall && state == S_ARMED && wen && is_prog;
  wire prog_all   = op == 2'b00;
  wire [DATA_W-1:0] prog_val = (op == 2'b11 || (op == 2'b00 && ext == 2'b10)) ? '1 : data_q;

  assign do_oe = cs_s && (state == S_START || state == S_HOLD || state == S_READ);
  assign do_o  = do_oe && ((state == S_READ) ? do_q : ~busy);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_m <= '0; sk_m <= '0; di_m <= '0; cs_d <= 1'b0; sk_d <= 1'b0;
    end else begin
      cs_m <= {cs_m[0], cs}; sk_m <= {sk_m[0], sk}; di_m <= {di_m[0], di};
      cs_d <= cs_s; sk_d <= sk_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cmd_q <= '0; data_q <= '0; out_sr <= '0;
      bit_cnt <= '0; do_q <= 1'b0; wen <= 1'b0;
    end else if (cs_fall) begin
      state <= S_IDLE;
      if (state == S_ARMED && op == 2'b00 && ext == 2'b11) wen <= 1'b1;
      if (state == S_ARMED && op == 2'b00 && ext == 2'b00) wen <= 1'b0;
    end else if (cs_rise) begin
      state <= busy ? S_HOLD : S_START;
    end else if (sk_rise && cs_s) begin
      case (state)
        S_START: if (di_s) begin state <= S_CMD; bit_cnt <= '0; end
        S_CMD: begin
          cmd_q   <= cmd_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_W'(CMD_W - 1)) begin
            if (nop == 2'b10) begin
              state  <= S_READ;
              do_q   <= 1'b0;
              out_sr <= mem[cmd_next[ADDR_W-1:0]];
            end else if (need_data) begin
              state   <= S_DATA;
              bit_cnt <= '0;
            end else state <= S_ARMED;
          end
        end
        S_DATA: begin
          data_q  <= {data_q[DATA_W-2:0], di_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BC_W'(DATA_W - 1)) state <= S_ARMED;
        end
        S_ARMED: state <= S_ABORT;
        S_READ: begin
          do_q   <= out_sr[DATA_W-1];
          out_sr <= {out_sr[DATA_W-2:0], 1'b0};
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prog_cnt <= '0;
    else if (prog_go) prog_cnt <= CNT_W'(PROG_CYCLES);
    else if (busy) prog_cnt <= prog_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (prog_go) begin
      for (int i = 0; i < WORDS; i++)
        if (prog_all || cmd_q[ADDR_W-1:0] == ADDR_W'(i)) mem[i] <= prog_val;
    end

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !do_oe |-> !do_o);
  a_r4_wen_on_cs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (wen != $past(wen)) |-> $past(cs_fall));
  a_r6_prog_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));
  a_r7_prog_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(state) == S_ARMED) && $past(cs_fall));
  a_r10_busy_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !do_o);
  a_r10_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> prog_cnt == $past(prog_cnt) - CNT_W'(1));
endmodule

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int PH   = 6;
  localparam int PROG = 100;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int n_chk = 0, n_fail = 0;

  mw_eeprom #(.ADDR_W(6), .DATA_W(16), .PROG_CYCLES(PROG)) i_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {command byte, data, read address, expected word}
  localparam logic [45:0] VEC [6] = '{
    {8'h45, 16'h1234, 6'd5,  16'h1234},
    {8'h7F, 16'hA5C3, 6'd63, 16'hA5C3},
    {8'h40, 16'h0001, 6'd0,  16'h0001},
    {8'hC5, 16'h0000, 6'd5,  16'hFFFF},
    {8'h4A, 16'h8000, 6'd10, 16'h8000},
    {8'h80, 16'h0000, 6'd63, 16'hA5C3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic obit);
    di = b; wait_clks(PH);
    sk = 1'b1; wait_clks(PH);
    obit = do_o;
    sk = 1'b0;
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [15:0] data, input bit ndata, input bit extra);
    logic o;
    cs = 1'b1; wait_clks(PH);
    send_bit(1'b1, o);
    for (int i = 7; i >= 0; i--) send_bit(cmd[i], o);
    if (ndata) for (int i = 15; i >= 0; i--) send_bit(data[i], o);
    if (extra) send_bit(1'b0, o);
    di = 1'b0; wait_clks(PH);
    cs = 1'b0; wait_clks(2*PH);
  endtask

  task automatic read_word(input logic [5:0] a, input int lead0, output logic [16:0] r);
    logic o;
    cs = 1'b1; wait_clks(PH);
    for (int i = 0; i < lead0; i++) send_bit(1'b0, o);
    send_bit(1'b1, o); send_bit(1'b1, o); send_bit(1'b0, o);
    for (int i = 5; i >= 0; i--) send_bit(a[i], o);
    r[16] = o;
    for (int i = 15; i >= 0; i--) begin send_bit(1'b0, o); r[i] = o; end
    cs = 1'b0; wait_clks(2*PH);
  endtask

  task automatic status(output logic oe, output logic d);
    cs = 1'b1; wait_clks(PH);
    oe = do_oe; d = do_o;
    cs = 1'b0; wait_clks(2*PH);
  endtask

  task automatic poll_ready(output int waited);
    waited = 0;
    cs = 1'b1; wait_clks(PH);
    while (do_o !== 1'b1 && waited < 2000) begin wait_clks(1); waited++; end
    cs = 1'b0; wait_clks(2*PH);
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [15:0] exp);
    logic [16:0] r;
    read_word(a, 0, r);
    chk(req, {15'd0, r}, {15'd0, 1'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic oe, d;
    logic [16:0] r;
    int w;
    wait_clks(5); rst_n = 1'b1; wait_clks(5);

    chk("R3 idle oe", {31'd0, do_oe}, 32'd0);
    chk("R3 idle do", {31'd0, do_o}, 32'd0);
    status(oe, d);
    chk("R10 ready oe", {31'd0, oe}, 32'd1);
    chk("R10 ready do", {31'd0, d}, 32'd1);
    read_word(6'd7, 0, r);
    chk("R11 reset word with R2 dummy", {15'd0, r}, {15'd0, 17'h0FFFF});

    txn(8'h43, 16'h1111, 1, 0);
    status(oe, d);
    chk("R6 no busy when latch clear", {31'd0, d}, 32'd1);
    rd_chk("R6 write ignored", 6'd3, 16'hFFFF);

    txn(8'h30, 16'h0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      logic [45:0] v;
      v = VEC[i];
      if (v[45:44] != 2'b10) begin
        txn(v[45:38], v[37:22], v[45:44] == 2'b01, 0);
        status(oe, d);
        chk("R10 busy oe", {31'd0, oe}, 32'd1);
        chk("R10 busy do", {31'd0, d}, 32'd0);
        poll_ready(w);
        chk("R10 ready in time", {31'd0, w <= PROG}, 32'd1);
      end
      rd_chk("R5 R8 table readback", v[21:16], v[15:0]);
    end

    read_word(6'd63, 3, r);
    chk("R1 leading zeros skipped", {15'd0, r}, {15'd0, 17'h0A5C3});

    txn(8'h5E, 16'h0F0F, 1, 1);
    status(oe, d);
    chk("R7 cancelled no busy", {31'd0, d}, 32'd1);
    rd_chk("R7 cancelled write", 6'd30, 16'hFFFF);

    txn(8'h68, 16'h4444, 1, 0);
    txn(8'h54, 16'h2020, 1, 0);
    poll_ready(w);
    rd_chk("R10 command during busy ignored", 6'd20, 16'hFFFF);
    rd_chk("R5 write before busy command", 6'd40, 16'h4444);

    txn(8'h10, 16'h5A5A, 1, 0);
    poll_ready(w);
    rd_chk("R9 write all w0", 6'd0, 16'h5A5A);
    rd_chk("R9 write all w33", 6'd33, 16'h5A5A);
    rd_chk("R9 write all w63", 6'd63, 16'h5A5A);

    txn(8'h20, 16'h0, 0, 0);
    poll_ready(w);
    rd_chk("R8 erase all w33", 6'd33, 16'hFFFF);
    rd_chk("R8 erase all w10", 6'd10, 16'hFFFF);

    txn(8'h00, 16'h0, 0, 0);
    txn(8'h42, 16'h2222, 1, 0);
    status(oe, d);
    chk("R4 disabled no busy", {31'd0, d}, 32'd1);
    rd_chk("R4 R6 write after disable ignored", 6'd2, 16'hFFFF);
    txn(8'hC2, 16'h0, 0, 0);
    chk("R3 oe low with cs low", {31'd0, do_oe}, 32'd0);

    txn(8'h30, 16'h0, 0, 0);
    txn(8'h42, 16'h00FF, 1, 0);
    poll_ready(w);
    rd_chk("R4 re-enabled write lands", 6'd2, 16'h00FF);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule